// File: doc/BRIEF.md
# Register-Pair Signed Multiply/Divide Unit

This unit carries out signed two's-complement multiplication and division on a 16-entry, 32-bit register file that it holds internally. Operations that produce or consume 64 bits use an even/odd register pair. The lower-numbered, even register carries the high half of the value and the odd register carries the low half. A single-register multiply with a 16-bit second operand is also provided. Each operation can take its second operand either from an input bus or from a second register.

A caller raises `start` for one cycle while `busy` is low, giving an opcode, a target register index and an operand. Multiplies and rejected requests finish after one busy cycle. Division runs a one-bit-per-cycle restoring divider on operand magnitudes and finishes after a fixed number of busy cycles. The end of every operation is marked by a one-cycle `done` pulse. That pulse can carry one of two failure flags: a division exception or a specification error. When either flag is raised, no register is written. A separate low-priority write port and a read port let the surrounding logic load and observe the register file.

Top module: `pair_muldiv`

## Requirements
- R1: Full-word multiply (op 0) needs an even target index. It multiplies the odd register of that pair by the 32-bit second operand. The even register receives product bits 63:32 and the odd register receives bits 31:0. The earlier content of the even register has no effect on the result.
- R2: When a full-word product fits in 32 bits, the even register holds the sign extension of the odd register (all ones or all zeros).
- R3: Half-word multiply (op 1) works on the single target register and accepts any index. The multiplier is bits 15:0 of the second operand, sign-extended; bits 31:16 of the second operand are ignored. Only bits 31:0 of the 48-bit product are written back, so the sign of the result can come out wrong when the product overflows.
- R4: Divide (op 2) needs an even target index. It divides the 64-bit pair (even register high) by the 32-bit second operand. The remainder goes to the even register and the quotient to the odd register. The quotient is truncated toward zero, and the remainder takes the sign of the dividend.
- R5: A divide with a zero divisor, or with a quotient outside the signed 32-bit range, raises `div_exc` together with `done` and leaves both registers unchanged.
- R6: An odd target index on op 0 or op 2, or the reserved op 3, raises `spec_err` together with `done`. No register is written in that case.
- R7: With `use_reg` high, the second operand is the register selected by `r2_in`, and `opnd_in` has no effect.
- R8: A request is accepted only while `busy` is low. Multiplies and rejected requests hold `busy` for exactly 1 cycle. Divides hold `busy` for exactly W+1 = 33 cycles. `done` is a one-cycle pulse raised in the cycle after `busy` falls.
- R9: A `start` raised while `busy` is high is ignored: it does not change the running operation, writes no register and produces no extra `done`.
- R10: After reset, `busy`, `done`, `div_exc` and `spec_err` are low and every register reads 0.
- R11: The external write port stores `ext_wdata` into register `ext_waddr` one clock edge after `ext_we`. The read port returns register `ext_raddr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request strobe, honoured while busy is low |
| op_in | input | 2 | 0 full multiply, 1 half multiply, 2 divide, 3 reserved |
| r1_in | input | 4 | Target register or even pair index |
| r2_in | input | 4 | Register supplying the second operand when use_reg is high |
| use_reg | input | 1 | Take the second operand from the register file |
| opnd_in | input | 32 | Second operand from the bus |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_exc | output | 1 | Division exception, valid with done |
| spec_err | output | 1 | Specification error, valid with done |
| ext_we | input | 1 | External register write enable |
| ext_waddr | input | 4 | External write index |
| ext_wdata | input | 32 | External write data |
| ext_raddr | input | 4 | Read index |
| ext_rdata | output | 32 | Read data |

## Verification
The bound checker watches the handshake on every cycle. It checks that `done` lasts a single cycle and never overlaps `busy`, that both failure flags appear only together with `done` and never together with each other, and that busy persists until completion. It also counts busy cycles, so the fixed latency of each accepted request is confirmed on every operation. Numeric results are a different matter: product halves, quotient and remainder signs, the rounding direction, half-word truncation, and registers left untouched on an exception or an ignored start can only be observed in the bench's scenarios, where registers are read back through the external port.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  typedef enum logic [1:0] {
    OP_MULF = 2'd0,
    OP_MULH = 2'd1,
    OP_DIV  = 2'd2,
    OP_RSV  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MUL  = 3'd1,
    ST_DIV  = 3'd2,
    ST_FIN  = 3'd3,
    ST_ERR  = 3'd4
  } st_e;
endpackage

// File: rtl/pmd_regfile.sv
module pmd_regfile #(
  parameter int W    = 32,
  parameter int NREG = 16,
  parameter int NRD  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_a,
  input  logic [AW-1:0]           wa_a,
  input  logic [W-1:0]            wd_a,
  input  logic                    we_b,
  input  logic [AW-1:0]           wa_b,
  input  logic [W-1:0]            wd_b,
  input  logic                    we_x,
  input  logic [AW-1:0]           wa_x,
  input  logic [W-1:0]            wd_x,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  logic [W-1:0] mem [NREG];

  // Unit ports A and B take precedence over the external port X.
  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic         hit_a, hit_b, hit_x, en;
    logic [W-1:0] d, q;

    always_comb begin
      hit_a = we_a && (wa_a == AW'(i));
      hit_b = we_b && (wa_b == AW'(i));
      hit_x = we_x && (wa_x == AW'(i));
      en    = hit_a || hit_b || hit_x;
      if (hit_a)      d = wd_a;
      else if (hit_b) d = wd_b;
      else            d = wd_x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign mem[i] = q;
  end

  for (genvar j = 0; j < NRD; j++) begin : g_rd
    assign rdata[j] = mem[raddr[j]];
  end
endmodule

// File: rtl/pmd_mul.sv
module pmd_mul #(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod_full,
  output logic [W-1:0]   prod_half
);
  logic [2*W-1:0] a_ext, b_ext;
  logic [W-1:0]   h_ext;

  always_comb begin
    a_ext     = {{W{mcand[W-1]}}, mcand};
    b_ext     = {{W{mplier[W-1]}}, mplier};
    prod_full = a_ext * b_ext;
    // Low W bits of a signed product equal those of the modular product.
    h_ext     = {{(W-HW){mplier[HW-1]}}, mplier[HW-1:0]};
    prod_half = mcand * h_ext;
  end
endmodule

// File: rtl/pmd_div.sv
module pmd_div #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld,
  input  logic           step,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic [W-1:0]   quo,
  output logic [W-1:0]   rem,
  output logic           exc
);
  logic [2*W-1:0] mag_dd;
  logic [W-1:0]   mag_ds;
  logic [W-1:0]   rem_q, rem_n, qsh_q, qsh_n, ds_q, ds_n;
  logic           negq_q, negq_n, negr_q, negr_n, ovf_q, ovf_n;
  logic [W:0]     trial, diff;
  logic           ge, en, big;

  always_comb begin
    mag_dd = dividend[2*W-1] ? -dividend : dividend;
    mag_ds = divisor[W-1] ? -divisor : divisor;
    trial  = {rem_q, qsh_q[W-1]};
    diff   = trial - {1'b0, ds_q};
    ge     = (trial >= {1'b0, ds_q});
    en     = ld || step;

    rem_n  = rem_q;
    qsh_n  = qsh_q;
    ds_n   = ds_q;
    negq_n = negq_q;
    negr_n = negr_q;
    ovf_n  = ovf_q;
    if (ld) begin
      rem_n  = mag_dd[2*W-1:W];
      qsh_n  = mag_dd[W-1:0];
      ds_n   = mag_ds;
      negq_n = dividend[2*W-1] ^ divisor[W-1];
      negr_n = dividend[2*W-1];
      // A high half at or above the divisor means a quotient of 2^W or more;
      // this also catches a zero divisor.
      ovf_n  = (mag_dd[2*W-1:W] >= mag_ds);
    end else if (step) begin
      rem_n  = ge ? diff[W-1:0] : trial[W-1:0];
      qsh_n  = {qsh_q[W-2:0], ge};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      qsh_q  <= '0;
      ds_q   <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (en) begin
      rem_q  <= rem_n;
      qsh_q  <= qsh_n;
      ds_q   <= ds_n;
      negq_q <= negq_n;
      negr_q <= negr_n;
      ovf_q  <= ovf_n;
    end
  end

  always_comb begin
    quo = negq_q ? -qsh_q : qsh_q;
    rem = negr_q ? -rem_q : rem_q;
    // Magnitude limit: 2^(W-1) for a negative quotient, 2^(W-1)-1 otherwise.
    big = qsh_q[W-1] && (!negq_q || (|qsh_q[W-2:0]));
    exc = ovf_q || big;
  end
endmodule

// File: rtl/pair_muldiv.sv
module pair_muldiv
  import pmd_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 16,
  parameter int HW   = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op_in,
  input  logic [AW-1:0] r1_in,
  input  logic [AW-1:0] r2_in,
  input  logic          use_reg,
  input  logic [W-1:0]  opnd_in,
  output logic          busy,
  output logic          done,
  output logic          div_exc,
  output logic          spec_err,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_waddr,
  input  logic [W-1:0]  ext_wdata,
  input  logic [AW-1:0] ext_raddr,
  output logic [W-1:0]  ext_rdata
);
  localparam int CW  = $clog2(W);
  localparam int NRD = 4;

  // Reset synchronizer: asserts asynchronously, releases on the clock.
  logic rs1, rs2, rst_c;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b0;
      rs2 <= 1'b0;
    end else begin
      rs1 <= 1'b1;
      rs2 <= rs1;
    end
  end
  assign rst_c = rs2;

  st_e             st_q, st_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  op_e             op_q, op_n;
  logic [AW-1:0]   r1_q, r1_n;
  logic [W-1:0]    a_q, a_n, b_q, b_n;
  logic            cap, ld, step;
  logic            done_n, dexc_n, serr_n, done_q, dexc_q, serr_q;

  logic [NRD-1:0][AW-1:0] rf_ra;
  logic [NRD-1:0][W-1:0]  rf_rd;
  logic                   we_a, we_b;
  logic [AW-1:0]          wa_a, wa_b;
  logic [W-1:0]           wd_a, wd_b;

  logic [2*W-1:0] p_full;
  logic [W-1:0]   p_half, d_quo, d_rem, b_sel;
  logic           d_exc, bad_req;
  op_e            op_cur;
  logic [AW-1:0]  ev_idx, od_idx;

  always_comb begin
    rf_ra[0] = r1_in;
    rf_ra[1] = {r1_in[AW-1:1], 1'b1};
    rf_ra[2] = r2_in;
    rf_ra[3] = ext_raddr;
  end
  assign ext_rdata = rf_rd[3];

  pmd_regfile #(.W(W), .NREG(NREG), .NRD(NRD)) u_rf (
    .clk   (clk),
    .rst_n (rst_c),
    .we_a  (we_a),
    .wa_a  (wa_a),
    .wd_a  (wd_a),
    .we_b  (we_b),
    .wa_b  (wa_b),
    .wd_b  (wd_b),
    .we_x  (ext_we),
    .wa_x  (ext_waddr),
    .wd_x  (ext_wdata),
    .raddr (rf_ra),
    .rdata (rf_rd)
  );

  pmd_mul #(.W(W), .HW(HW)) u_mul (
    .mcand     (a_q),
    .mplier    (b_q),
    .prod_full (p_full),
    .prod_half (p_half)
  );

  pmd_div #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_c),
    .ld       (ld),
    .step     (step),
    .dividend ({rf_rd[0], rf_rd[1]}),
    .divisor  (b_sel),
    .quo      (d_quo),
    .rem      (d_rem),
    .exc      (d_exc)
  );

  always_comb begin
    op_cur  = op_e'(op_in);
    b_sel   = use_reg ? rf_rd[2] : opnd_in;
    bad_req = (op_cur == OP_RSV) ||
              (((op_cur == OP_MULF) || (op_cur == OP_DIV)) && r1_in[0]);
    ev_idx  = {r1_q[AW-1:1], 1'b0};
    od_idx  = {r1_q[AW-1:1], 1'b1};
  end

  // Next-state and write control.
  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    cap   = 1'b0;
    ld    = 1'b0;
    step  = 1'b0;
    we_a  = 1'b0;
    we_b  = 1'b0;
    wa_a  = ev_idx;
    wa_b  = od_idx;
    wd_a  = p_full[2*W-1:W];
    wd_b  = p_full[W-1:0];
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          cap = 1'b1;
          if (bad_req) begin
            st_n = ST_ERR;
          end else if (op_cur == OP_DIV) begin
            st_n  = ST_DIV;
            ld    = 1'b1;
            cnt_n = '0;
          end else begin
            st_n = ST_MUL;
          end
        end
      end
      ST_MUL: begin
        st_n = ST_IDLE;
        if (op_q == OP_MULH) begin
          we_a = 1'b1;
          wa_a = r1_q;
          wd_a = p_half;
        end else begin
          we_a = 1'b1;
          we_b = 1'b1;
        end
      end
      ST_DIV: begin
        step  = 1'b1;
        cnt_n = cnt_q + CW'(1);
        if (cnt_q == CW'(W-1)) st_n = ST_FIN;
      end
      ST_FIN: begin
        st_n = ST_IDLE;
        if (!d_exc) begin
          we_a = 1'b1;
          we_b = 1'b1;
          wd_a = d_rem;
          wd_b = d_quo;
        end
      end
      ST_ERR:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase

    op_n = op_q;
    r1_n = r1_q;
    a_n  = a_q;
    b_n  = b_q;
    if (cap) begin
      op_n = op_cur;
      r1_n = r1_in;
      a_n  = (op_cur == OP_MULF) ? rf_rd[1] : rf_rd[0];
      b_n  = b_sel;
    end

    done_n = (st_q == ST_MUL) || (st_q == ST_FIN) || (st_q == ST_ERR);
    dexc_n = (st_q == ST_FIN) && d_exc;
    serr_n = (st_q == ST_ERR);
  end

  always_ff @(posedge clk or negedge rst_c) begin
    if (!rst_c) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      dexc_q <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
      dexc_q <= dexc_n;
      serr_q <= serr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_c) begin
    if (!rst_c) begin
      op_q <= OP_MULF;
      r1_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else if (cap) begin
      op_q <= op_n;
      r1_q <= r1_n;
      a_q  <= a_n;
      b_q  <= b_n;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign div_exc  = dexc_q;
  assign spec_err = serr_q;
endmodule

// File: rtl/pmd_checker.sv
module pmd_checker
  import pmd_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    op_in,
  input logic [AW-1:0] r1_in,
  input logic          busy,
  input logic          done,
  input logic          div_exc,
  input logic          spec_err
);
  localparam int LW = $clog2(W + 2) + 1;

  logic [LW-1:0] lat_cnt, lat_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      lat_exp <= LW'(1);
    end else if (start && !busy) begin
      lat_cnt <= '0;
      lat_exp <= ((op_in == OP_DIV) && !r1_in[0]) ? LW'(W + 1) : LW'(1);
    end else if (busy) begin
      lat_cnt <= lat_cnt + LW'(1);
    end
  end

  // R8: completion pulse is a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: completion never overlaps busy
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: fixed number of busy cycles per accepted request
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == lat_exp));

  // R5: exception flag only with completion
  a_r5_exc_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    div_exc |-> (done && !spec_err));

  // R6: specification error only with completion
  a_r6_spec_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    spec_err |-> done);

  // R9: a start during busy does not end or restart the operation early
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
endmodule

bind pair_muldiv pmd_checker #(.W(W), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .op_in    (op_in),
  .r1_in    (r1_in),
  .busy     (busy),
  .done     (done),
  .div_exc  (div_exc),
  .spec_err (spec_err)
);

// File: tb/pair_muldiv_tb.sv
module pair_muldiv_tb;
  localparam int W = 32;

  logic        clk, rst_n, start, use_reg, busy, done, div_exc, spec_err;
  logic [1:0]  op_in;
  logic [3:0]  r1_in, r2_in, ext_waddr, ext_raddr;
  logic [31:0] opnd_in, ext_wdata, ext_rdata;
  logic        ext_we;

  int checks = 0;
  int fails  = 0;

  pair_muldiv u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_in), .r1_in(r1_in),
    .r2_in(r2_in), .use_reg(use_reg), .opnd_in(opnd_in), .busy(busy),
    .done(done), .div_exc(div_exc), .spec_err(spec_err), .ext_we(ext_we),
    .ext_waddr(ext_waddr), .ext_wdata(ext_wdata), .ext_raddr(ext_raddr),
    .ext_rdata(ext_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  r1;
    logic [31:0] hi;
    logic [31:0] lo;
    logic [31:0] b;
    logic [31:0] ehi;
    logic [31:0] elo;
    logic        exc;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd2,  32'hDEADBEEF, 32'h00003800, 32'h00000003, 32'h00000000, 32'h0000A800, 1'b0},
    '{2'd0, 4'd4,  32'h12345678, 32'hFFFFFF9C, 32'h00000064, 32'hFFFFFFFF, 32'hFFFFD8F0, 1'b0},
    '{2'd0, 4'd6,  32'h00000000, 32'h80000000, 32'h80000000, 32'h40000000, 32'h00000000, 1'b0},
    '{2'd0, 4'd8,  32'h00000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h80000001, 1'b0},
    '{2'd1, 4'd3,  32'h00000000, 32'h00001000, 32'hABCD0010, 32'h00000000, 32'h00010000, 1'b0},
    '{2'd1, 4'd5,  32'h00000000, 32'h00010000, 32'h0000FF9C, 32'h00000000, 32'hFF9C0000, 1'b0},
    '{2'd1, 4'd7,  32'h00000000, 32'h00020000, 32'h00004000, 32'h00000000, 32'h80000000, 1'b0},
    '{2'd2, 4'd10, 32'h00000000, 32'h00000064, 32'h00000007, 32'h00000002, 32'h0000000E, 1'b0},
    '{2'd2, 4'd12, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'h00000007, 32'hFFFFFFFE, 32'hFFFFFFF2, 1'b0},
    '{2'd2, 4'd14, 32'h00000000, 32'h00000064, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFF2, 1'b0},
    '{2'd2, 4'd0,  32'h00000001, 32'h00000000, 32'h00000003, 32'h00000001, 32'h55555555, 1'b0},
    '{2'd2, 4'd2,  32'h00000000, 32'h00000005, 32'h00000000, 32'h00000000, 32'h00000005, 1'b1},
    '{2'd2, 4'd4,  32'h00000000, 32'h80000000, 32'h00000001, 32'h00000000, 32'h80000000, 1'b1},
    '{2'd2, 4'd6,  32'hFFFFFFFF, 32'h80000000, 32'h00000001, 32'h00000000, 32'h80000000, 1'b0},
    '{2'd2, 4'd8,  32'hFFFFFFFF, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFFFFD, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    ext_we = 1'b1; ext_waddr = a; ext_wdata = d;
    @(negedge clk);
    ext_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    ext_raddr = a;
    #1;
    d = ext_rdata;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [3:0] r1, input logic [3:0] r2,
                        input logic ur, input logic [31:0] b,
                        output int lat, output logic dx, output logic se);
    @(negedge clk);
    start = 1'b1; op_in = op; r1_in = r1; r2_in = r2; use_reg = ur; opnd_in = b;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 100);
    dx = div_exc;
    se = spec_err;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 actual=no done expected=done");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d0, d1;
    int          lat, dn;
    logic        dx, se;
    vec_t        v;
    string       tag;

    rst_n = 1'b0; start = 1'b0; op_in = '0; r1_in = '0; r2_in = '0;
    use_reg = 1'b0; opnd_in = '0; ext_we = 1'b0; ext_waddr = '0;
    ext_wdata = '0; ext_raddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    check("R10 busy", {31'd0, busy}, 32'd0);
    check("R10 done", {31'd0, done}, 32'd0);
    check("R10 flags", {30'd0, div_exc, spec_err}, 32'd0);
    rd(4'd9, d0);
    check("R10 reg", d0, 32'd0);

    // R11: external port write then read
    wr(4'd13, 32'hCAFEF00D);
    rd(4'd13, d0);
    check("R11 readback", d0, 32'hCAFEF00D);

    // Table of vectors: R1, R3, R4, R5, R8
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      if (v.op == 2'd1) begin
        wr(v.r1, v.lo);
      end else begin
        wr({v.r1[3:1], 1'b0}, v.hi);
        wr({v.r1[3:1], 1'b1}, v.lo);
      end
      run_op(v.op, v.r1, 4'd0, 1'b0, v.b, lat, dx, se);
      tag = (v.op == 2'd0) ? "R1" : (v.op == 2'd1) ? "R3" : (v.exc ? "R5" : "R4");
      if (v.op == 2'd1) begin
        rd(v.r1, d1);
        check(tag, d1, v.elo);
      end else begin
        rd({v.r1[3:1], 1'b0}, d0);
        rd({v.r1[3:1], 1'b1}, d1);
        check({tag, " even"}, d0, v.ehi);
        check({tag, " odd"}, d1, v.elo);
      end
      check({tag, " exc flag"}, {31'd0, dx}, {31'd0, v.exc});
      check("R8 latency", lat, (v.op == 2'd2) ? W + 2 : 2);
    end

    // R2: small negative product sign-extends into the even register
    wr(4'd2, 32'h0F0F0F0F);
    wr(4'd3, 32'hFFFFFFFB);
    run_op(2'd0, 4'd2, 4'd0, 1'b0, 32'd7, lat, dx, se);
    rd(4'd2, d0); rd(4'd3, d1);
    check("R2 odd", d1, 32'hFFFFFFDD);
    check("R2 even", d0, {32{d1[31]}});

    // R7: register operand for multiply, bus operand ignored
    wr(4'd9, 32'd5);
    wr(4'd3, 32'd7);
    run_op(2'd0, 4'd2, 4'd9, 1'b1, 32'h00001234, lat, dx, se);
    rd(4'd2, d0); rd(4'd3, d1);
    check("R7 mul even", d0, 32'd0);
    check("R7 mul odd", d1, 32'd35);

    // R7: register operand for divide
    wr(4'd11, 32'hFFFFFFF9);
    wr(4'd4, 32'd0);
    wr(4'd5, 32'd100);
    run_op(2'd2, 4'd4, 4'd11, 1'b1, 32'd3, lat, dx, se);
    rd(4'd4, d0); rd(4'd5, d1);
    check("R7 div rem", d0, 32'd2);
    check("R7 div quo", d1, 32'hFFFFFFF2);

    // R6: odd pair index on full multiply
    wr(4'd2, 32'h11);
    wr(4'd3, 32'h22);
    run_op(2'd0, 4'd3, 4'd0, 1'b0, 32'd2, lat, dx, se);
    rd(4'd2, d0); rd(4'd3, d1);
    check("R6 mul flag", {31'd0, se}, 32'd1);
    check("R6 mul even kept", d0, 32'h11);
    check("R6 mul odd kept", d1, 32'h22);
    check("R6 latency", lat, 2);

    // R6: odd pair index on divide, and reserved opcode
    run_op(2'd2, 4'd3, 4'd0, 1'b0, 32'd2, lat, dx, se);
    rd(4'd2, d0); rd(4'd3, d1);
    check("R6 div flag", {31'd0, se}, 32'd1);
    check("R6 div kept", d1, 32'h22);
    run_op(2'd3, 4'd2, 4'd0, 1'b0, 32'd2, lat, dx, se);
    rd(4'd2, d0);
    check("R6 rsv flag", {31'd0, se}, 32'd1);
    check("R6 rsv kept", d0, 32'h11);

    // R9: start during a divide is ignored
    wr(4'd10, 32'd0);
    wr(4'd11, 32'd100);
    wr(4'd4, 32'hAA);
    wr(4'd5, 32'hBB);
    @(negedge clk);
    start = 1'b1; op_in = 2'd2; r1_in = 4'd10; use_reg = 1'b0; opnd_in = 32'd7;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after accept", {31'd0, busy}, 32'd1);
    @(negedge clk);
    start = 1'b1; op_in = 2'd0; r1_in = 4'd4; opnd_in = 32'd2;
    @(negedge clk);
    start = 1'b0;
    dn = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (done) dn++;
    end
    check("R9 done count", dn, 1);
    rd(4'd10, d0); rd(4'd11, d1);
    check("R9 div rem", d0, 32'd2);
    check("R9 div quo", d1, 32'd14);
    rd(4'd4, d0); rd(4'd5, d1);
    check("R9 even untouched", d0, 32'hAA);
    check("R9 odd untouched", d1, 32'hBB);

    summary();
    $finish;
  end
endmodule